// File: doc/BRIEF.md
# Prescaled 64-bit Alarm Timer

This block is a general-purpose time base. A 16-bit clock divider produces a tick every N clock cycles. Each tick moves a 64-bit counter one step up or one step down. Software starts and halts the counter with an enable bit. Halting keeps both the count and the divider phase, so counting resumes where it stopped.

A 64-bit alarm register is compared for equality with the counter. When the alarm is armed and the two values match, the alarm fires and disarms itself. On the fire it can raise a sticky level interrupt, a one-cycle pulse, or both. It can also reload the counter from a 64-bit reload register. Software can load the same reload register into the counter at any time by writing a command address.

Reading the 64-bit count over a 32-bit port works through a snapshot. A write to a capture address copies the whole count into a holding register. Both halves are then read from that register and come from the same cycle.

Top module: `alarm_timer64`

## Requirements
- R1: After reset the counter, the snapshot and every control field are zero, the counter is halted, and both interrupt outputs are low.
- R2: Writing address 0 sets the control word: bit 0 run, bit 1 count up (1) or down (0), bit 2 auto-reload, bit 3 alarm armed, bit 4 level interrupt enable, bit 5 pulse interrupt enable, bits 31:16 divider field. While running with division N, the counter makes one step every N clocks. When the write changes the divider field, the first step comes N clock edges after the write edge.
- R3: A divider field of 0 divides by 65536. A field of 1 divides by 2, the same as a field of 2.
- R4: An up count adds one per step and a down count subtracts one. Both wrap modulo 2^64, so a down step from zero gives all ones, and a carry passes from the low 32 bits into the high 32 bits.
- R5: With the run bit clear, neither the count nor the divider phase moves. Setting run again with the same divider field continues from the held phase.
- R6: A write to address 2 loads the counter from the reload value at that edge, whether or not the counter runs or an alarm is armed. The reload value is low word at address 8 and high word at address 9.
- R7: The alarm fires in a cycle where the arm bit is set and the count equals the alarm value (low word at address 12, high word at address 13). The edge that ends that cycle clears the arm bit, and the alarm does not fire again until software arms it.
- R8: With auto-reload set, the edge after the match loads the counter from the reload value. Without auto-reload, counting carries on past the alarm value.
- R9: With the level enable set, a fire sets irq_level from the next edge onward. It stays high until a write to address 3. Reading address 3 returns the level flag in bit 0.
- R10: With the pulse enable set, a fire drives irq_pulse high for exactly one cycle, starting at the next edge. With the enable clear, irq_pulse stays low.
- R11: A write to address 1 copies the count into the snapshot. Addresses 4 (low word) and 5 (high word) return that copy, and it does not change as the counter keeps running.
- R12: A control write that changes the divider field restarts the divider phase from zero, including when the counter is halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_level | output | 1 | Sticky alarm interrupt |
| irq_pulse | output | 1 | One-cycle alarm interrupt |

## Verification
A register write takes effect at the edge that samples it. A snapshot holds the count as it stood before its capture edge. An interrupt follows the matching count by one edge. After a write that changes the divider field, the first counter step comes N edges later. The bench waits an exact number of edges after each write and samples at the next falling edge. It takes snapshots on the edge just before and just after each predicted step, matching interrupt, halt and resume, so a result that lands one cycle early or one cycle late fails a check.

// File: rtl/tmr64_pkg.sv
package tmr64_pkg;

  localparam int unsigned DIV_W = 16;

  localparam logic [3:0] A_CTRL       = 4'd0;
  localparam logic [3:0] A_SNAP       = 4'd1;
  localparam logic [3:0] A_RELOAD     = 4'd2;
  localparam logic [3:0] A_IRQ        = 4'd3;
  localparam logic [3:0] A_SNAP_BASE  = 4'd4;
  localparam logic [3:0] A_LOAD_BASE  = 4'd8;
  localparam logic [3:0] A_ALARM_BASE = 4'd12;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [9:0]       rsv;
    logic             edge_en;
    logic             lvl_en;
    logic             arm;
    logic             auto_rl;
    logic             up;
    logic             run;
  } ctrl_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] pcnt_q, pcnt_d;
  logic [DIV_W-1:0] term;

  // terminal phase: field 0 -> all ones (2^DIV_W), field 1 -> 1 (divide by 2)
  always_comb begin
    if (div == '0)       term = '1;
    else if (div == ONE) term = ONE;
    else                 term = div - ONE;
  end

  assign tick = run && (pcnt_q == term);

  always_comb begin
    pcnt_d = pcnt_q;
    if (restart)   pcnt_d = '0;
    else if (tick) pcnt_d = '0;
    else if (run)  pcnt_d = pcnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             up,
  input  logic             sw_load,
  input  logic             auto_rl,
  input  logic             arm,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] alarm_val,
  output logic [CNT_W-1:0] count,
  output logic             fire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign fire  = arm && (cnt_q == alarm_val);
  assign count = cnt_q;

  // priority: software load, then reload on alarm, then a counting step
  always_comb begin
    cnt_d = cnt_q;
    if (sw_load)              cnt_d = load_val;
    else if (fire && auto_rl) cnt_d = load_val;
    else if (step)            cnt_d = up ? (cnt_q + ONE) : (cnt_q - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic lvl_en,
  input  logic edge_en,
  input  logic clr,
  output logic irq_level,
  output logic irq_pulse
);
  logic lvl_q, lvl_d, pls_q, pls_d;

  always_comb begin
    lvl_d = lvl_q;
    if (clr)            lvl_d = 1'b0;
    if (fire && lvl_en) lvl_d = 1'b1;
    pls_d = fire && edge_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      pls_q <= pls_d;
    end
  end

  assign irq_level = lvl_q;
  assign irq_pulse = pls_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr64_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  count,
  input  logic              fire,
  input  logic              irq_level,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  alarm_val,
  output logic              div_restart,
  output logic              sw_load,
  output logic              irq_clr
);
  localparam int unsigned NW = CNT_W / DATA_W;

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] load_q, load_d, alarm_q, alarm_d, snap_q, snap_d;
  logic [NW-1:0]    ld_we, al_we, sn_re;
  logic             wr_ctrl, wr_snap;
  ctrl_t            ctrl_new;

  assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign wr_snap  = wr_en && (wr_addr == ADDR_W'(A_SNAP));
  assign sw_load  = wr_en && (wr_addr == ADDR_W'(A_RELOAD));
  assign irq_clr  = wr_en && (wr_addr == ADDR_W'(A_IRQ));
  assign ctrl_new = ctrl_t'(wr_data[31:0]);
  assign div_restart = wr_ctrl && (ctrl_new.div != ctrl_q.div);

  genvar w;
  generate
    for (w = 0; w < NW; w++) begin : g_word
      assign ld_we[w] = wr_en && (wr_addr == ADDR_W'(A_LOAD_BASE + w));
      assign al_we[w] = wr_en && (wr_addr == ADDR_W'(A_ALARM_BASE + w));
      assign sn_re[w] = (rd_addr == ADDR_W'(A_SNAP_BASE + w));
    end
  endgenerate

  always_comb begin
    ctrl_d = ctrl_q;
    if (fire)    ctrl_d.arm = 1'b0;
    if (wr_ctrl) ctrl_d = ctrl_new;
    load_d  = load_q;
    alarm_d = alarm_q;
    for (int i = 0; i < NW; i++) begin
      if (ld_we[i]) load_d[i*DATA_W +: DATA_W]  = wr_data;
      if (al_we[i]) alarm_d[i*DATA_W +: DATA_W] = wr_data;
    end
    snap_d = wr_snap ? count : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      alarm_q <= '0;
      snap_q  <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      load_q  <= load_d;
      alarm_q <= alarm_d;
      snap_q  <= snap_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(A_CTRL)) rd_data = DATA_W'(ctrl_q);
    if (rd_addr == ADDR_W'(A_IRQ))  rd_data = DATA_W'(irq_level);
    for (int i = 0; i < NW; i++) begin
      if (sn_re[i]) rd_data = snap_q[i*DATA_W +: DATA_W];
    end
  end

  assign ctrl      = ctrl_q;
  assign load_val  = load_q;
  assign alarm_val = alarm_q;
endmodule

// File: rtl/alarm_timer64.sv
module alarm_timer64
  import tmr64_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_level,
  output logic              irq_pulse
);
  ctrl_t            ctrl_w;
  logic [CNT_W-1:0] load_w, alarm_w, count_w;
  logic             div_restart_w, sw_load_w, irq_clr_w, tick_w, fire_w;

  tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .count(count_w), .fire(fire_w),
    .irq_level(irq_level), .ctrl(ctrl_w), .load_val(load_w), .alarm_val(alarm_w),
    .div_restart(div_restart_w), .sw_load(sw_load_w), .irq_clr(irq_clr_w)
  );

  tmr_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_w.run), .restart(div_restart_w),
    .div(ctrl_w.div), .tick(tick_w)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(tick_w), .up(ctrl_w.up), .sw_load(sw_load_w),
    .auto_rl(ctrl_w.auto_rl), .arm(ctrl_w.arm), .load_val(load_w),
    .alarm_val(alarm_w), .count(count_w), .fire(fire_w)
  );

  tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .fire(fire_w), .lvl_en(ctrl_w.lvl_en),
    .edge_en(ctrl_w.edge_en), .clr(irq_clr_w), .irq_level(irq_level),
    .irq_pulse(irq_pulse)
  );
endmodule

// File: rtl/tmr64_checker.sv
module tmr64_checker
  import tmr64_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              irq_level,
  input logic              irq_pulse,
  input logic              fire,
  input logic              tick,
  input logic              sw_load,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  load_val,
  input ctrl_t             ctrl
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic clr_wr, ctrl_wr;
  assign clr_wr  = wr_en && (wr_addr == ADDR_W'(A_IRQ));
  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(A_CTRL));

  p_up_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && ctrl.up && !sw_load && !(fire && ctrl.auto_rl) |=> count == $past(count) + ONE);
  p_down_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ctrl.up && !sw_load && !(fire && ctrl.auto_rl) |=> count == $past(count) - ONE);
  p_halt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run && !sw_load && !fire |=> $stable(count));
  p_sw_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_load |=> count == $past(load_val));
  p_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !ctrl_wr |=> !ctrl.arm);
  p_auto_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ctrl.auto_rl && !sw_load |=> count == $past(load_val));
  p_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level && !clr_wr |=> irq_level);
  p_level_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && !fire |=> !irq_level);
  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  p_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pulse) |-> $past(fire));
endmodule

bind alarm_timer64 tmr64_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .irq_level(irq_level), .irq_pulse(irq_pulse), .fire(fire_w), .tick(tick_w),
  .sw_load(sw_load_w), .count(count_w), .load_val(load_w), .ctrl(ctrl_w)
);

// File: tb/sim_alarm_timer64.sv
module sim_alarm_timer64;
  logic        clk, rst_n, wr_en, irq_level, irq_pulse, mon_go, done;
  logic [3:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  int          total, bad;

  typedef struct {
    int          src;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  alarm_timer64 u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_level(irq_level), .irq_pulse(irq_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // monitor: pops the expected item and compares in the middle of the cycle
  always @(negedge clk) begin
    if (mon_go && sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = (it.src == 0) ? rd_data : (it.src == 1) ? {31'b0, irq_level} : {31'b0, irq_pulse};
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s src=%0d actual=%h expected=%h", it.req, it.src, act, it.exp);
      end
    end
  end

  function automatic logic [31:0] cw(input logic [15:0] div, input logic pe, input logic le,
                                      input logic arm, input logic ar, input logic up,
                                      input logic run);
    return {div, 10'b0, pe, le, arm, ar, up, run};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // src 0: read rd_addr, 1: irq_level, 2: irq_pulse
  task automatic chk(input int src, input logic [3:0] a, input logic [31:0] e, input string req);
    item_t it;
    it.src = src; it.exp = e; it.req = req;
    sb_q.push_back(it);
    rd_addr = a; mon_go = 1'b1;
    @(posedge clk); #1;
    mon_go = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 1'b0; mon_go = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    rst_n = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk(0, 4'd0, 32'h0, "R1");
    chk(1, 4'd0, 32'h0, "R1");
    chk(2, 4'd0, 32'h0, "R1");
    chk(0, 4'd4, 32'h0, "R1");
    chk(0, 4'd3, 32'h0, "R1");

    // R2 / R12 / R11: divide by 4 up from 0x10; control write at edge W
    wr(4'd8, 32'h10); wr(4'd9, 0); wr(4'd2, 0);
    wr(4'd0, cw(16'd4, 0, 0, 0, 0, 1, 1));
    idle(3);
    wr(4'd1, 0);                          // capture at W+4: value after W+3
    chk(0, 4'd4, 32'h10, "R2 R12 no step before N edges");
    wr(4'd1, 0);                          // capture at W+6: value after W+5
    chk(0, 4'd4, 32'h11, "R2 first step");
    chk(0, 4'd5, 32'h0, "R11 high word");
    idle(10);
    chk(0, 4'd4, 32'h11, "R11 snapshot stable");

    // R6 software reload while running
    wr(4'd0, cw(16'd100, 0, 0, 0, 0, 1, 1));
    wr(4'd8, 32'hA5A5_0001); wr(4'd9, 32'h7); wr(4'd2, 0);
    wr(4'd1, 0);
    chk(0, 4'd4, 32'hA5A5_0001, "R6 low");
    chk(0, 4'd5, 32'h7, "R6 high");

    // R7 R8 R9 R10: auto-reload alarm across the 32-bit carry, divide by 8
    wr(4'd0, cw(16'd100, 0, 0, 0, 0, 1, 0));
    wr(4'd8, 32'hFFFF_FFFE); wr(4'd9, 0); wr(4'd2, 0);
    wr(4'd12, 0); wr(4'd13, 1);
    wr(4'd0, cw(16'd8, 1, 1, 1, 1, 1, 1));  // edge W; match after W+16
    idle(15);
    chk(2, 4'd0, 0, "R10 before match");
    chk(2, 4'd0, 0, "R10 match cycle");
    chk(2, 4'd0, 1, "R10 pulse");
    chk(2, 4'd0, 0, "R10 single cycle");
    chk(1, 4'd0, 1, "R9 level set");
    chk(0, 4'd3, 1, "R9 level read");
    wr(4'd1, 0);
    chk(0, 4'd4, 32'hFFFF_FFFE, "R8 reloaded low");
    chk(0, 4'd5, 32'h0, "R8 reloaded high");
    chk(0, 4'd0, cw(16'd8, 1, 1, 0, 1, 1, 1), "R7 arm cleared");
    wr(4'd3, 0);
    chk(1, 4'd0, 0, "R9 cleared");
    idle(40);
    chk(1, 4'd0, 0, "R7 no refire");

    // R8 R4 R9 R10 R5: no auto-reload, down count, divide by 3
    wr(4'd0, cw(16'd8, 0, 0, 0, 0, 1, 0));
    wr(4'd8, 32'h5); wr(4'd9, 0); wr(4'd2, 0);
    wr(4'd12, 32'h3); wr(4'd13, 0);
    wr(4'd0, cw(16'd3, 0, 1, 1, 0, 0, 1));  // edge W; count 3 after W+6
    idle(6);
    chk(1, 4'd0, 0, "R9 not before match");
    chk(1, 4'd0, 1, "R9 one edge after match");
    chk(2, 4'd0, 0, "R10 disabled");
    wr(4'd0, cw(16'd3, 0, 1, 0, 0, 0, 0));  // halt at W+10
    wr(4'd1, 0);
    chk(0, 4'd4, 32'h2, "R8 counts past alarm");
    idle(10);
    wr(4'd1, 0);
    chk(0, 4'd4, 32'h2, "R5 held");
    wr(4'd0, cw(16'd3, 0, 1, 0, 0, 0, 1));  // resume at R
    idle(2);
    wr(4'd1, 0);                          // capture at R+3
    chk(0, 4'd4, 32'h1, "R5 phase kept");
    wr(4'd3, 0);

    // R3 R4: field 1 divides by 2, down wrap from zero
    wr(4'd0, cw(16'd3, 0, 0, 0, 0, 0, 0));
    wr(4'd8, 0); wr(4'd9, 0); wr(4'd2, 0);
    wr(4'd0, cw(16'd1, 0, 0, 0, 0, 0, 1));  // edge W
    idle(1);
    wr(4'd1, 0);                          // capture at W+2
    chk(0, 4'd4, 32'h0, "R3 field 1 not every cycle");
    wr(4'd0, cw(16'd1, 0, 0, 0, 0, 0, 0));  // halt at W+4
    wr(4'd1, 0);
    chk(0, 4'd4, 32'hFFFF_FFFE, "R4 wrap low");
    chk(0, 4'd5, 32'hFFFF_FFFF, "R4 wrap high");

    // R3 R12: field 0 divides by 65536
    wr(4'd8, 32'h100); wr(4'd9, 0); wr(4'd2, 0);
    wr(4'd0, cw(16'd0, 0, 0, 0, 0, 1, 1));  // edge W
    idle(65535);
    wr(4'd1, 0);                          // capture at W+65536
    chk(0, 4'd4, 32'h100, "R3 no step before 65536");
    wr(4'd1, 0);                          // capture at W+65538
    chk(0, 4'd4, 32'h101, "R3 R12 step at 65536");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule